// File: doc/BRIEF.md
# Private Interrupt Pending Tracker

This block holds the per-core state of 32 private interrupts. Numbers 0 to 15 are software-generated interrupts (SGIs), and numbers 16 to 31 are peripheral interrupts, each driven by a line. The block keeps three bitmaps: the enable bitmap, the pending latch and the active bitmap. It shows a pending view in which each level-triggered peripheral line is ORed into its latch bit. An edge-triggered line instead latches pending on its rising edge.

SGI requests arrive on a valid/ready stream, one request per transfer. Each request carries the interrupt number, the group it asks for and a non-secure flag. Before a request may set its pending bit, it must pass a group check and a per-interrupt permission check.

Bitmap updates come from the register decoder on a second valid/ready stream. That stream carries an operation code and a 32-bit value, with the security mask already applied. Both streams raise ready one clock after reset is released and then hold it high every cycle, so they never apply back-pressure. A transfer takes place in any cycle in which valid and ready are both high.

The configuration arrives on plain input pins: the trigger mode of each line, the configured group of each SGI, the permission field of each SGI and a security-off flag. Priority arbitration and register decode sit outside this block. An update strobe tells the arbiter that some state has changed.

Top module: `pir_core`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, pend_view, enable_map, active_map and upd_strobe are all zero. From the second clock after release onward, sgi_ready and wr_ready are high.
- R2: A bitmap write transfer with wr_op 0 ORs wr_data into the enable bitmap and wr_op 1 clears the enable bits that wr_data marks. wr_op 2 and 3 do the same for the pending latch, and wr_op 4 and 5 for the active bitmap. wr_op 6 and 7 leave all state unchanged.
- R3: Bit 16+k of pend_view is the pending latch ORed with the sampled level of ppi_level[k] whenever edge_cfg[k] is 0 (level-triggered). Clearing the latch of a level line that is still high therefore leaves the bit set. SGIs have no line.
- R4: The level of each peripheral line is sampled once per clock. A 0-to-1 change on a line with edge_cfg[k]=1 sets latch bit 16+k. A level line never sets the latch, and a line that holds its level has no effect.
- R5: Group codes are 0 = secure group 0, 1 = secure group 1, 2 = non-secure group 1 and 3 = reserved. A request for code 1 is first folded to code 0 when the SGI is configured as code 0. The request is then dropped if its group differs from the configured group, or if the configured group is the reserved code.
- R6: Bits [2n+1:2n] of sgi_nsacc hold the permission field of SGI n. The field is checked only when sgi_ns=1 and sec_off=0. A configured group 0 then needs a value of at least 1, and a configured group 1 needs at least 2. A failing request is dropped. Configured group 2 is not limited.
- R7: An accepted SGI sets bit sgi_id of the pending latch. The bit can be seen on the clock after the transfer.
- R8: If the same pending bit is both set (by an SGI, a write or a line edge) and cleared in one cycle, the set wins.
- R9: upd_strobe is high for exactly the cycles in which some state register took a new value at the preceding edge. The state registers are the enable bitmap, the pending latch, the active bitmap and the sampled line levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ppi_level | input | 16 | Peripheral line levels, bit k is interrupt 16+k |
| edge_cfg | input | 16 | 1 = line k is edge-triggered, 0 = level-triggered |
| sgi_grp_cfg | input | 32 | Configured group code of each SGI, two bits per SGI |
| sgi_nsacc | input | 32 | Non-secure permission field of each SGI, two bits per SGI |
| sec_off | input | 1 | 1 = security disabled, permission check skipped |
| sgi_valid | input | 1 | SGI request valid |
| sgi_ready | output | 1 | SGI request ready |
| sgi_id | input | 4 | SGI number |
| sgi_grp | input | 2 | Requested group code |
| sgi_ns | input | 1 | Request comes from the non-secure side |
| wr_valid | input | 1 | Bitmap write valid |
| wr_ready | output | 1 | Bitmap write ready |
| wr_op | input | 3 | Bitmap operation code |
| wr_data | input | 32 | Masked write value, one bit per interrupt |
| pend_view | output | 32 | Pending view (latch, plus the level of each level-triggered line) |
| enable_map | output | 32 | Enable bitmap |
| active_map | output | 32 | Active bitmap |
| upd_strobe | output | 1 | Some state changed at the last edge |

## Verification
All three bitmaps, the sampled line levels and the strobe are registered. An input applied before a rising edge is therefore visible just after that edge, one cycle later, and the strobe rises in the same cycle as the change it reports. The bench drives every input on the falling edge and reads the outputs on the next falling edge, half a period after the edge that captured them. For cases where nothing may change, it looks again one cycle later to confirm that the strobe has dropped and the bitmaps have kept their values.

// File: rtl/pir_pkg.sv
`timescale 1ns/1ps
package pir_pkg;

  localparam logic [2:0] OP_EN_SET   = 3'd0;
  localparam logic [2:0] OP_EN_CLR   = 3'd1;
  localparam logic [2:0] OP_PEND_SET = 3'd2;
  localparam logic [2:0] OP_PEND_CLR = 3'd3;
  localparam logic [2:0] OP_ACT_SET  = 3'd4;
  localparam logic [2:0] OP_ACT_CLR  = 3'd5;

  localparam logic [1:0] GRP_S0   = 2'd0;
  localparam logic [1:0] GRP_S1   = 2'd1;
  localparam logic [1:0] GRP_NS1  = 2'd2;
  localparam logic [1:0] GRP_RSVD = 2'd3;

  // A secure group 1 request lands on a group 0 SGI as group 0.
  function automatic logic [1:0] fold_group(input logic [1:0] req, input logic [1:0] cfg);
    logic [1:0] r;
    r = req;
    if (req == GRP_S1 && cfg == GRP_S0) r = GRP_S0;
    return r;
  endfunction

  // Permission threshold per configured group, applied only when check is set.
  function automatic logic ns_permit(input logic [1:0] cfg, input logic [1:0] acc,
                                     input logic check);
    logic ok;
    ok = 1'b1;
    if (check) begin
      case (cfg)
        GRP_S0:  ok = (acc >= 2'd1);
        GRP_S1:  ok = (acc >= 2'd2);
        default: ok = 1'b1;
      endcase
    end
    return ok;
  endfunction

endpackage

// File: rtl/pir_sgi_gate.sv
`timescale 1ns/1ps
module pir_sgi_gate
  import pir_pkg::*;
#(
  parameter int NUM_SGI = 16,
  parameter int ID_W    = 4
) (
  input  logic                 req_fire,
  input  logic [ID_W-1:0]      req_id,
  input  logic [1:0]           req_grp,
  input  logic                 req_ns,
  input  logic                 sec_off,
  input  logic [2*NUM_SGI-1:0] grp_cfg,
  input  logic [2*NUM_SGI-1:0] acc_cfg,
  output logic                 accept,
  output logic [NUM_SGI-1:0]   set_vec
);

  localparam logic [ID_W:0] ID_LIMIT = (ID_W+1)'(NUM_SGI);

  logic [1:0] cfg_grp;
  logic [1:0] acc_lvl;
  logic [1:0] eff_grp;
  logic       id_ok;
  logic       grp_ok;
  logic       perm_ok;

  always_comb begin
    cfg_grp = GRP_RSVD;
    acc_lvl = 2'd0;
    for (int k = 0; k < NUM_SGI; k++) begin
      if (req_id == ID_W'(k)) begin
        cfg_grp = grp_cfg[2*k +: 2];
        acc_lvl = acc_cfg[2*k +: 2];
      end
    end
    id_ok   = ({1'b0, req_id} < ID_LIMIT);
    eff_grp = fold_group(req_grp, cfg_grp);
    grp_ok  = (eff_grp == cfg_grp) && (cfg_grp != GRP_RSVD);
    perm_ok = ns_permit(cfg_grp, acc_lvl, req_ns && !sec_off);
    accept  = req_fire && id_ok && grp_ok && perm_ok;
  end

  for (genvar g = 0; g < NUM_SGI; g++) begin : g_dec
    assign set_vec[g] = accept && (req_id == ID_W'(g));
  end

endmodule

// File: rtl/pir_line_sampler.sv
`timescale 1ns/1ps
module pir_line_sampler #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] level_in,
  input  logic [NUM_LINES-1:0] edge_cfg,
  output logic [NUM_LINES-1:0] level_q,
  output logic [NUM_LINES-1:0] rise,
  output logic                 changed
);

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_in;
  end

  assign rise    = level_in & ~level_q & edge_cfg;
  assign changed = |(level_in ^ level_q);

endmodule

// File: rtl/pir_bitmap_reg.sv
`timescale 1ns/1ps
module pir_bitmap_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_mask,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] q,
  output logic             changed
);

  logic [WIDTH-1:0] nxt;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    // Set has priority over clear on the same bit.
    assign nxt[b] = set_mask[b] | (q[b] & ~clr_mask[b]);
    always_ff @(posedge clk) begin
      if (!rst_n) q[b] <= 1'b0;
      else        q[b] <= nxt[b];
    end
  end

  assign changed = |(nxt ^ q);

endmodule

// File: rtl/pir_core.sv
`timescale 1ns/1ps
module pir_core
  import pir_pkg::*;
#(
  parameter int NUM_SGI = 16,
  parameter int NUM_PPI = 16,
  localparam int NUM_IRQ = NUM_SGI + NUM_PPI,
  localparam int ID_W    = $clog2(NUM_SGI),
  localparam int CFG_W   = 2 * NUM_SGI
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_PPI-1:0] ppi_level,
  input  logic [NUM_PPI-1:0] edge_cfg,
  input  logic [CFG_W-1:0]   sgi_grp_cfg,
  input  logic [CFG_W-1:0]   sgi_nsacc,
  input  logic               sec_off,
  input  logic               sgi_valid,
  output logic               sgi_ready,
  input  logic [ID_W-1:0]    sgi_id,
  input  logic [1:0]         sgi_grp,
  input  logic               sgi_ns,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [2:0]         wr_op,
  input  logic [NUM_IRQ-1:0] wr_data,
  output logic [NUM_IRQ-1:0] pend_view,
  output logic [NUM_IRQ-1:0] enable_map,
  output logic [NUM_IRQ-1:0] active_map,
  output logic               upd_strobe
);

  logic ready_q;
  logic upd_q;
  logic sgi_fire;
  logic wr_fire;
  logic sgi_accept;
  logic [NUM_SGI-1:0] sgi_set;
  logic [NUM_PPI-1:0] lvl_q;
  logic [NUM_PPI-1:0] lvl_rise;
  logic               lvl_chg;
  logic [NUM_IRQ-1:0] en_set, en_clr, pd_set, pd_clr, ac_set, ac_clr;
  logic [NUM_IRQ-1:0] pend_latch;
  logic               en_chg, pd_chg, ac_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign sgi_ready = ready_q;
  assign wr_ready  = ready_q;
  assign sgi_fire  = sgi_valid && ready_q;
  assign wr_fire   = wr_valid && ready_q;

  pir_sgi_gate #(.NUM_SGI(NUM_SGI), .ID_W(ID_W)) u_gate (
    .req_fire (sgi_fire),
    .req_id   (sgi_id),
    .req_grp  (sgi_grp),
    .req_ns   (sgi_ns),
    .sec_off  (sec_off),
    .grp_cfg  (sgi_grp_cfg),
    .acc_cfg  (sgi_nsacc),
    .accept   (sgi_accept),
    .set_vec  (sgi_set)
  );

  pir_line_sampler #(.NUM_LINES(NUM_PPI)) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (ppi_level),
    .edge_cfg (edge_cfg),
    .level_q  (lvl_q),
    .rise     (lvl_rise),
    .changed  (lvl_chg)
  );

  always_comb begin
    en_set = (wr_fire && wr_op == OP_EN_SET)   ? wr_data : '0;
    en_clr = (wr_fire && wr_op == OP_EN_CLR)   ? wr_data : '0;
    ac_set = (wr_fire && wr_op == OP_ACT_SET)  ? wr_data : '0;
    ac_clr = (wr_fire && wr_op == OP_ACT_CLR)  ? wr_data : '0;
    pd_clr = (wr_fire && wr_op == OP_PEND_CLR) ? wr_data : '0;
    pd_set = ((wr_fire && wr_op == OP_PEND_SET) ? wr_data : '0)
           | {lvl_rise, sgi_set};
  end

  pir_bitmap_reg #(.WIDTH(NUM_IRQ)) u_enable (
    .clk (clk), .rst_n (rst_n), .set_mask (en_set), .clr_mask (en_clr),
    .q (enable_map), .changed (en_chg)
  );

  pir_bitmap_reg #(.WIDTH(NUM_IRQ)) u_pending (
    .clk (clk), .rst_n (rst_n), .set_mask (pd_set), .clr_mask (pd_clr),
    .q (pend_latch), .changed (pd_chg)
  );

  pir_bitmap_reg #(.WIDTH(NUM_IRQ)) u_active (
    .clk (clk), .rst_n (rst_n), .set_mask (ac_set), .clr_mask (ac_clr),
    .q (active_map), .changed (ac_chg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= en_chg | pd_chg | ac_chg | lvl_chg;
  end

  assign upd_strobe = upd_q;
  assign pend_view  = pend_latch | {lvl_q & ~edge_cfg, {NUM_SGI{1'b0}}};

endmodule

// File: rtl/pir_checker.sv
`timescale 1ns/1ps
module pir_checker
  import pir_pkg::*;
#(
  parameter int NUM_SGI = 16,
  parameter int NUM_PPI = 16,
  localparam int NUM_IRQ = NUM_SGI + NUM_PPI,
  localparam int ID_W    = $clog2(NUM_SGI),
  localparam int CFG_W   = 2 * NUM_SGI
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_PPI-1:0] ppi_level,
  input logic [NUM_PPI-1:0] edge_cfg,
  input logic [NUM_PPI-1:0] lvl_q,
  input logic [CFG_W-1:0]   sgi_grp_cfg,
  input logic [CFG_W-1:0]   sgi_nsacc,
  input logic               sec_off,
  input logic               sgi_valid,
  input logic               sgi_ready,
  input logic [ID_W-1:0]    sgi_id,
  input logic [1:0]         sgi_grp,
  input logic               sgi_ns,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [2:0]         wr_op,
  input logic [NUM_IRQ-1:0] wr_data,
  input logic [NUM_IRQ-1:0] pend_view,
  input logic [NUM_IRQ-1:0] enable_map,
  input logic [NUM_IRQ-1:0] active_map,
  input logic               upd_strobe
);

  logic               wr_go;
  logic [NUM_PPI-1:0] rise_c;
  logic [1:0]         cfg_c;
  logic [1:0]         acc_c;
  logic               blocked_c;
  logic [NUM_IRQ-1:0] blk_mask;

  always_comb begin
    wr_go  = wr_valid && wr_ready;
    rise_c = ppi_level & ~lvl_q & edge_cfg;
    cfg_c  = 2'd0;
    acc_c  = 2'd0;
    for (int k = 0; k < NUM_SGI; k++) begin
      if (sgi_id == ID_W'(k)) begin
        cfg_c = sgi_grp_cfg[2*k +: 2];
        acc_c = sgi_nsacc[2*k +: 2];
      end
    end
    blocked_c = sgi_valid && sgi_ready && sgi_ns && !sec_off &&
                sgi_grp == GRP_S0 && cfg_c == GRP_S0 && acc_c == 2'd0 &&
                !(wr_go && (wr_op == OP_PEND_SET || wr_op == OP_PEND_CLR));
    blk_mask  = blocked_c ? (NUM_IRQ'(1) << sgi_id) : '0;
  end

  assert_pend_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && wr_op == OP_PEND_SET) |=> ((pend_view & $past(wr_data)) == $past(wr_data)));

  assert_en_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && wr_op == OP_EN_CLR) |=> ((enable_map & $past(wr_data)) == '0));

  assert_edge_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_c) |=> ((pend_view[NUM_IRQ-1:NUM_SGI] & $past(rise_c)) == $past(rise_c)));

  assert_ns_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_c |=> ((pend_view & $past(blk_mask)) == ($past(pend_view) & $past(blk_mask))));

  assert_strobe_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_map != $past(enable_map)) |-> upd_strobe);

  assert_strobe_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_map != $past(active_map)) |-> upd_strobe);

endmodule

bind pir_core pir_checker #(.NUM_SGI(NUM_SGI), .NUM_PPI(NUM_PPI)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ppi_level   (ppi_level),
  .edge_cfg    (edge_cfg),
  .lvl_q       (lvl_q),
  .sgi_grp_cfg (sgi_grp_cfg),
  .sgi_nsacc   (sgi_nsacc),
  .sec_off     (sec_off),
  .sgi_valid   (sgi_valid),
  .sgi_ready   (sgi_ready),
  .sgi_id      (sgi_id),
  .sgi_grp     (sgi_grp),
  .sgi_ns      (sgi_ns),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_op       (wr_op),
  .wr_data     (wr_data),
  .pend_view   (pend_view),
  .enable_map  (enable_map),
  .active_map  (active_map),
  .upd_strobe  (upd_strobe)
);

// File: tb/sim_pir_core.sv
`timescale 1ns/1ps
module sim_pir_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ppi_level;
  logic [15:0] edge_cfg;
  logic [31:0] sgi_grp_cfg;
  logic [31:0] sgi_nsacc;
  logic        sec_off;
  logic        sgi_valid;
  logic        sgi_ready;
  logic [3:0]  sgi_id;
  logic [1:0]  sgi_grp;
  logic        sgi_ns;
  logic        wr_valid;
  logic        wr_ready;
  logic [2:0]  wr_op;
  logic [31:0] wr_data;
  logic [31:0] pend_view;
  logic [31:0] enable_map;
  logic [31:0] active_map;
  logic        upd_strobe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pir_core u0 (
    .clk (clk), .rst_n (rst_n), .ppi_level (ppi_level), .edge_cfg (edge_cfg),
    .sgi_grp_cfg (sgi_grp_cfg), .sgi_nsacc (sgi_nsacc), .sec_off (sec_off),
    .sgi_valid (sgi_valid), .sgi_ready (sgi_ready), .sgi_id (sgi_id),
    .sgi_grp (sgi_grp), .sgi_ns (sgi_ns), .wr_valid (wr_valid),
    .wr_ready (wr_ready), .wr_op (wr_op), .wr_data (wr_data),
    .pend_view (pend_view), .enable_map (enable_map), .active_map (active_map),
    .upd_strobe (upd_strobe)
  );

  // Vector: {id[12:9], req grp[8:7], ns[6], cfg grp[5:4], perm[3:2], sec_off[1], accept[0]}
  localparam logic [12:0] VECS [13] = '{
    {4'd3,  2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1},
    {4'd5,  2'd1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1},
    {4'd5,  2'd1, 1'b0, 2'd2, 2'd0, 1'b0, 1'b0},
    {4'd7,  2'd2, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0},
    {4'd2,  2'd0, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0},
    {4'd2,  2'd0, 1'b1, 2'd0, 2'd1, 1'b0, 1'b1},
    {4'd9,  2'd1, 1'b1, 2'd1, 2'd1, 1'b0, 1'b0},
    {4'd9,  2'd1, 1'b1, 2'd1, 2'd2, 1'b0, 1'b1},
    {4'd9,  2'd1, 1'b1, 2'd1, 2'd0, 1'b1, 1'b1},
    {4'd12, 2'd2, 1'b1, 2'd2, 2'd0, 1'b0, 1'b1},
    {4'd15, 2'd1, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0},
    {4'd0,  2'd3, 1'b0, 2'd3, 2'd0, 1'b0, 1'b0},
    {4'd14, 2'd0, 1'b1, 2'd1, 2'd3, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_cycle(input logic [2:0] op, input logic [31:0] data);
    wr_valid = 1'b1; wr_op = op; wr_data = data;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; ppi_level = '0; edge_cfg = '0; sgi_grp_cfg = '0; sgi_nsacc = '0;
    sec_off = 1'b0; sgi_valid = 1'b0; sgi_id = '0; sgi_grp = '0; sgi_ns = 1'b0;
    wr_valid = 1'b0; wr_op = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 pend in reset", pend_view, 32'h0);
    rst_n = 1'b1;
    idle(); idle();
    chk("R1 pend after reset", pend_view, 32'h0);
    chk("R1 enable after reset", enable_map, 32'h0);
    chk("R1 active after reset", active_map, 32'h0);
    chk("R1 strobe after reset", {31'h0, upd_strobe}, 32'h0);
    chk("R1 ready", {30'h0, sgi_ready, wr_ready}, 32'h3);

    // R5 R6 R7: acceptance table
    for (int i = 0; i < 13; i++) begin
      sgi_grp_cfg = {16{VECS[i][5:4]}};
      sgi_nsacc   = {16{VECS[i][3:2]}};
      sec_off     = VECS[i][1];
      wr_cycle(3'd3, 32'hFFFF_FFFF);
      sgi_valid = 1'b1; sgi_id = VECS[i][12:9]; sgi_grp = VECS[i][8:7]; sgi_ns = VECS[i][6];
      @(negedge clk);
      sgi_valid = 1'b0;
      chk($sformatf("R5 R6 R7 vector %0d pending", i), pend_view,
          VECS[i][0] ? (32'h1 << VECS[i][12:9]) : 32'h0);
      chk($sformatf("R9 vector %0d strobe", i), {31'h0, upd_strobe}, {31'h0, VECS[i][0]});
    end
    sec_off = 1'b0; sgi_grp_cfg = '0; sgi_nsacc = '0;
    wr_cycle(3'd3, 32'hFFFF_FFFF);
    idle();

    // R2 enable set and clear
    wr_cycle(3'd0, 32'hF0F0_00FF);
    chk("R2 enable set", enable_map, 32'hF0F0_00FF);
    chk("R9 strobe on enable change", {31'h0, upd_strobe}, 32'h1);
    idle();
    chk("R9 strobe drops when idle", {31'h0, upd_strobe}, 32'h0);
    wr_cycle(3'd1, 32'h0000_00F0);
    chk("R2 enable clear", enable_map, 32'hF0F0_000F);
    idle();
    wr_cycle(3'd0, 32'h0000_000F);
    chk("R9 no strobe on redundant set", {31'h0, upd_strobe}, 32'h0);
    chk("R2 redundant set keeps enable", enable_map, 32'hF0F0_000F);
    // R2 unused opcodes
    wr_cycle(3'd7, 32'hFFFF_FFFF);
    chk("R2 op7 enable unchanged", enable_map, 32'hF0F0_000F);
    chk("R2 op7 active unchanged", active_map, 32'h0);
    chk("R2 op7 pending unchanged", pend_view, 32'h0);
    wr_cycle(3'd6, 32'hFFFF_FFFF);
    chk("R2 op6 state unchanged", enable_map | active_map | pend_view, 32'hF0F0_000F);
    // R2 active set and clear
    wr_cycle(3'd4, 32'h0001_8001);
    chk("R2 active set", active_map, 32'h0001_8001);
    wr_cycle(3'd5, 32'h0000_8000);
    chk("R2 active clear", active_map, 32'h0001_0001);

    // R3 level-triggered view
    edge_cfg = 16'h0000; ppi_level = 16'h0010;
    idle();
    chk("R3 level shows in view", pend_view, 32'h0010_0000);
    wr_cycle(3'd3, 32'h0010_0000);
    chk("R3 clear with level high keeps view", pend_view, 32'h0010_0000);
    ppi_level = 16'h0000;
    idle();
    chk("R4 level line did not latch", pend_view, 32'h0);

    // R4 edge-triggered latch
    edge_cfg = 16'h0020; ppi_level = 16'h0020;
    idle();
    chk("R4 rising edge latches", pend_view, 32'h0020_0000);
    wr_cycle(3'd3, 32'h0020_0000);
    chk("R3 edge line not ORed after clear", pend_view, 32'h0);
    idle();
    chk("R4 steady high does not relatch", pend_view, 32'h0);
    ppi_level = 16'h0000;
    idle();
    chk("R4 falling edge no latch", pend_view, 32'h0);
    ppi_level = 16'h0020;
    idle();
    chk("R4 second rise latches", pend_view, 32'h0020_0000);
    ppi_level = 16'h0000;
    idle();

    // R8 set wins over clear in one cycle
    sgi_valid = 1'b1; sgi_id = 4'd3; sgi_grp = 2'd0; sgi_ns = 1'b0;
    wr_cycle(3'd3, 32'hFFFF_FFFF);
    sgi_valid = 1'b0;
    chk("R8 SGI set beats clear", pend_view, 32'h0000_0008);
    // R2 pending set and clear via writes
    wr_cycle(3'd2, 32'h8000_0002);
    chk("R2 pending set", pend_view, 32'h8000_000A);
    wr_cycle(3'd3, 32'h0000_0008);
    chk("R2 pending clear", pend_view, 32'h8000_0002);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule